// File: doc/BRIEF.md
# Configurable Foldback NAND Logic Fabric

This block models a fuse-programmed logic array whose core is a row of NAND terms. Every core term can be wired to any dedicated input and any bidirectional pad input, each in true or complement form, and to the output of an earlier core term. A ring of edge terms around the core drives the pins. These edge terms are wide ANDs over the same line set. The pins are bidirectional drivers with one enable each, dedicated outputs of mixed polarity, and exclusive-OR cells. Dedicated outputs and XOR cells are enabled in pairs.

Configuration arrives one bit per clock on a serial port and collects in a shift chain. A separate commit strobe copies the chain into the active configuration, so loading never disturbs live logic. A recall strobe copies the active configuration back into the chain, which lets it be shifted out for checking. A lock strobe mutes that readback until reset. After reset the active configuration is all zeros, which is the unprogrammed state. In that state every connection is open and every enable term is true. Bidirectional pads are split into a receive input and a drive output, and the drive output floats when it is disabled. The serial port has no back-pressure: a bit is taken on every clock where `prog_en` is high.

Top module: `foldback_nand_fabric`

## Requirements
- R1: After reset, with no commit since, out_o[3:0] drive 1, out_o[7:4] drive 0, every xor_o bit drives 0, bidir_o[3:0] drive 0 and bidir_o[7:4] drive 1, all enabled.
- R2: When prog_en is high, each clock shifts prog_bit into the chain, and the first bit shifted lands at configuration index 0. Shifted bits change no output until commit is pulsed, and commit copies the whole chain.
- R3: Configuration index t*136+k connects line k to term t. Lines 0-23 are din true, 24-47 are din complement, 48-55 are bidir_i true, 56-63 are bidir_i complement, and 64+c is core term c. A core term outputs the NAND of its connected lines, and a term with no connections outputs 0.
- R4: Core term j uses core term c only when c < j. Bits that connect a core term to itself or to a later core term are ignored.
- R5: Terms 72+b (b=0..7) are the bidir data terms and terms 80+b are their enables. A disabled bidir_o bit floats. bidir_o[7:4] drive the AND of their data term.
- R6: Terms 88+o (o=0..7) are the output data terms, and term 96+p enables out_o[2p] and out_o[2p+1]. out_o[3:0] drive the AND of their data term, out_o[7:4] drive its complement, and disabled pins float.
- R7: xor_o[x] drives the AND of term 100+2x XOR the AND of term 101+2x. Term 116+p enables xor_o[2p] and xor_o[2p+1].
- R8: Configuration bit 16320+b (b=0..3) sets bidir_o[b] active-high when it is 1. When it is 0 the pin drives the complement of its data term, and that is the default.
- R9: Pulsing recall loads the active configuration into the chain. rdbk_bit then shows index 0, and each further prog_en clock moves on to the next index.
- R10: After lock_set is pulsed, rdbk_bit stays 0 until reset, whatever is stored. The fabric's logic is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores the unprogrammed state and clears the lock |
| prog_en | input | 1 | Shift enable for the serial chain |
| prog_bit | input | 1 | Serial configuration data in |
| commit | input | 1 | Copies the chain into the active configuration |
| recall | input | 1 | Copies the active configuration into the chain; wins over prog_en |
| lock_set | input | 1 | Sets the sticky readback lock |
| rdbk_bit | output | 1 | Serial readback, chain index 0 (0 when locked) |
| din | input | 24 | Dedicated inputs |
| bidir_i | input | 8 | Bidirectional pad receive values |
| bidir_o | output | 8 | Bidirectional pad drive, high-Z when disabled |
| out_o | output | 8 | Dedicated outputs, high-Z when their pair is disabled |
| xor_o | output | 8 | Exclusive-OR outputs, high-Z when their pair is disabled |

## Verification
The assertions take for granted that recall, commit and prog_en come from synchronous logic and stay at known levels from reset onward. The rule that a recall overrides a shift in the same clock is one of the properties, so it is an assumption about the block's own chain and not about its inputs. The stimulus never raises recall and prog_en together. It raises commit only when the shift is idle, and it drives every strobe on the falling edge. The dedicated and pad inputs change only while configuration is idle, so the combinational outputs are sampled settled, half a period after each change.

// File: rtl/fnf_pkg.sv
package fnf_pkg;
  // Number of lines a term can select from
  function automatic int line_count(int n_in, int n_bio, int n_core);
    return 2 * n_in + 2 * n_bio + n_core;
  endfunction

  // Edge terms: bidir data + bidir enables + output data + output pair
  // enables + two per XOR cell + XOR pair enables
  function automatic int edge_count(int n_bio, int n_out, int n_xor);
    return 2 * n_bio + n_out + n_out / 2 + 2 * n_xor + n_xor / 2;
  endfunction
endpackage

// File: rtl/fnf_cfg_chain.sv
module fnf_cfg_chain #(
  parameter int TOTAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             prog_bit,
  input  logic             commit,
  input  logic             recall,
  input  logic             lock_set,
  output logic             rdbk_bit,
  output logic [TOTAL-1:0] active
);
  logic [TOTAL-1:0] chain;
  logic             locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      active <= '0;
      locked <= 1'b0;
    end else begin
      if (recall)       chain <= active;
      else if (prog_en) chain <= {prog_bit, chain[TOTAL-1:1]};
      if (commit)       active <= chain;
      if (lock_set)     locked <= 1'b1;
    end
  end

  assign rdbk_bit = locked ? 1'b0 : chain[0];

  p_hold_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !recall) |=> chain[TOTAL-1] == $past(prog_bit));
  p_recall_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recall |=> chain == $past(active));
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_lock_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> !rdbk_bit);
endmodule

// File: rtl/fnf_core.sv
module fnf_core #(
  parameter int N_CORE = 8,
  parameter int PIN_L  = 8,
  parameter int LINES  = PIN_L + N_CORE
) (
  input  logic [PIN_L-1:0]             pin_lines,
  input  logic [N_CORE-1:0][LINES-1:0] cfg,
  output logic [N_CORE-1:0]            core_out
);
  // Terms are evaluated in index order; only earlier terms feed later ones
  always_comb begin
    logic [N_CORE-1:0] acc;
    acc = '0;
    for (int j = 0; j < N_CORE; j++) begin
      logic [N_CORE-1:0] below;
      logic [N_CORE-1:0] fold_sel;
      for (int i = 0; i < N_CORE; i++) below[i] = (i < j);
      fold_sel = cfg[j][LINES-1:PIN_L] & below;
      acc[j] = ~&{(~fold_sel | acc), (~cfg[j][PIN_L-1:0] | pin_lines)};
    end
    core_out = acc;
  end
endmodule

// File: rtl/fnf_edge.sv
module fnf_edge #(
  parameter int N_BIO  = 8,
  parameter int N_OUT  = 8,
  parameter int N_XOR  = 8,
  parameter int LINES  = 16,
  parameter int N_EDGE = fnf_pkg::edge_count(N_BIO, N_OUT, N_XOR)
) (
  input  logic [LINES-1:0]             lines,
  input  logic [N_EDGE-1:0][LINES-1:0] cfg,
  input  logic [N_BIO/2-1:0]           pol,
  output wire  [N_BIO-1:0]             bidir_o,
  output wire  [N_OUT-1:0]             out_o,
  output wire  [N_XOR-1:0]             xor_o
);
  localparam int E_BD = 0;
  localparam int E_BE = E_BD + N_BIO;
  localparam int E_OD = E_BE + N_BIO;
  localparam int E_OE = E_OD + N_OUT;
  localparam int E_XD = E_OE + N_OUT / 2;
  localparam int E_XE = E_XD + 2 * N_XOR;

  logic [N_EDGE-1:0] t_and;

  for (genvar e = 0; e < N_EDGE; e++) begin : g_term
    assign t_and[e] = &(~cfg[e] | lines);
  end

  for (genvar b = 0; b < N_BIO; b++) begin : g_bidir
    logic drv;
    if (b < N_BIO / 2) begin : g_fuse_pol
      assign drv = pol[b] ? t_and[E_BD+b] : ~t_and[E_BD+b];
    end else begin : g_high
      assign drv = t_and[E_BD+b];
    end
    assign bidir_o[b] = t_and[E_BE+b] ? drv : 1'bz;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic drv;
    if (o < N_OUT / 2) begin : g_high
      assign drv = t_and[E_OD+o];
    end else begin : g_low
      assign drv = ~t_and[E_OD+o];
    end
    assign out_o[o] = t_and[E_OE+o/2] ? drv : 1'bz;
  end

  for (genvar x = 0; x < N_XOR; x++) begin : g_xor
    assign xor_o[x] = t_and[E_XE+x/2] ? (t_and[E_XD+2*x] ^ t_and[E_XD+2*x+1]) : 1'bz;
  end
endmodule

// File: rtl/foldback_nand_fabric.sv
module foldback_nand_fabric #(
  parameter int N_IN   = 24,
  parameter int N_BIO  = 8,
  parameter int N_CORE = 72,
  parameter int N_OUT  = 8,
  parameter int N_XOR  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             prog_bit,
  input  logic             commit,
  input  logic             recall,
  input  logic             lock_set,
  output logic             rdbk_bit,
  input  logic [N_IN-1:0]  din,
  input  logic [N_BIO-1:0] bidir_i,
  output wire  [N_BIO-1:0] bidir_o,
  output wire  [N_OUT-1:0] out_o,
  output wire  [N_XOR-1:0] xor_o
);
  localparam int LINES   = fnf_pkg::line_count(N_IN, N_BIO, N_CORE);
  localparam int PIN_L   = LINES - N_CORE;
  localparam int N_EDGE  = fnf_pkg::edge_count(N_BIO, N_OUT, N_XOR);
  localparam int N_TERMS = N_CORE + N_EDGE;
  localparam int N_POL   = N_BIO / 2;
  localparam int TOTAL   = N_TERMS * LINES + N_POL;

  logic [TOTAL-1:0]                 active;
  logic [N_CORE-1:0][LINES-1:0]     core_cfg;
  logic [N_EDGE-1:0][LINES-1:0]     edge_cfg;
  logic [N_POL-1:0]                 pol;
  logic [N_CORE-1:0]                core_out;
  logic [PIN_L-1:0]                 pin_lines;

  fnf_cfg_chain #(.TOTAL(TOTAL)) u_chain (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_bit(prog_bit),
    .commit(commit), .recall(recall), .lock_set(lock_set),
    .rdbk_bit(rdbk_bit), .active(active)
  );

  assign core_cfg  = active[N_CORE*LINES-1:0];
  assign edge_cfg  = active[N_TERMS*LINES-1:N_CORE*LINES];
  assign pol       = active[TOTAL-1 -: N_POL];
  assign pin_lines = {~bidir_i, bidir_i, ~din, din};

  fnf_core #(.N_CORE(N_CORE), .PIN_L(PIN_L), .LINES(LINES)) u_core (
    .pin_lines(pin_lines), .cfg(core_cfg), .core_out(core_out)
  );

  fnf_edge #(.N_BIO(N_BIO), .N_OUT(N_OUT), .N_XOR(N_XOR), .LINES(LINES),
             .N_EDGE(N_EDGE)) u_edge (
    .lines({core_out, pin_lines}), .cfg(edge_cfg), .pol(pol),
    .bidir_o(bidir_o), .out_o(out_o), .xor_o(xor_o)
  );

  // Tracks whether any configuration has been made live since reset
  logic seen_commit;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_commit <= 1'b0;
    else if (commit) seen_commit <= 1'b1;
  end

  localparam logic [N_OUT-1:0] VIRGIN_OUT = {{(N_OUT/2){1'b0}}, {(N_OUT/2){1'b1}}};
  localparam logic [N_BIO-1:0] VIRGIN_BD  = {{(N_BIO/2){1'b1}}, {(N_BIO/2){1'b0}}};

  p_virgin_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_commit |-> (out_o === VIRGIN_OUT && xor_o === '0 && bidir_o === VIRGIN_BD));
endmodule

// File: tb/foldback_nand_fabric_tb_top.sv
module foldback_nand_fabric_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 136;
  localparam int NT    = 120;
  localparam int TOTAL = NT * LINES + 4;
  localparam int NVEC  = 14;
  // stimulus: {bidir_i[7:0], din[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00_0000, 24'h04_0003, 24'h08_0024, 24'h0C_0058, 24'h00_0070,
    24'h04_0080, 24'h00_0180, 24'h08_0200, 24'h00_0C00, 24'h04_0800,
    24'h00_1000, 24'h0C_2005, 24'h00_3FFF, 24'hFF_FFFF};

  logic clk = 0, rst_n = 0;
  logic prog_en = 0, prog_bit = 0, commit = 0, recall = 0, lock_set = 0;
  logic rdbk_bit;
  logic [23:0] din = '0;
  logic [7:0]  bidir_i = '0;
  tri1  [7:0]  bidir_o, out_o, xor_o;
  int n_chk = 0, n_fail = 0;
  logic [TOTAL-1:0] img;

  always #(CLK_PERIOD/2) clk = ~clk;

  foldback_nand_fabric dut_i (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_bit(prog_bit),
    .commit(commit), .recall(recall), .lock_set(lock_set), .rdbk_bit(rdbk_bit),
    .din(din), .bidir_i(bidir_i), .bidir_o(bidir_o), .out_o(out_o), .xor_o(xor_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void con(int term, int line);
    img[term*LINES + line] = 1'b1;
  endfunction

  // Floating pins read as 1 through the bench pull-ups
  function automatic logic fz(logic en, logic v);
    return en ? v : 1'b1;
  endfunction

  task automatic apply(input logic [23:0] v);
    @(negedge clk);
    din = {8'h00, v[15:0]};
    bidir_i = v[23:16];
    #1;
  endtask

  task automatic check_prog(input logic [23:0] v, input string tag);
    logic [15:0] d;
    logic [7:0] bi, eo, ex, eb;
    d = v[15:0]; bi = v[23:16];
    eo[0] = d[0] & d[1];                 // R6 AND, direct
    eo[1] = d[4] ? d[6] : d[5];          // R3 R4 multiplexer through foldback
    eo[2] = ~d[7];                       // R4 later term ignored
    eo[3] = ~d[9];                       // R4 self link ignored
    eo[4] = d[0] & d[1];                 // R6 active-low of a NAND term
    eo[5] = 1'b0;
    eo[6] = fz(d[12], 1'b0);
    eo[7] = fz(d[12], 1'b0);
    ex = 8'h00;
    ex[0] = d[2] ^ d[3];                 // R7
    ex[2] = fz(~d[13], 1'b0);
    ex[3] = fz(~d[13], 1'b0);
    eb[0] = fz(d[11], ~d[10]);           // R5 R8 default active-low
    eb[1] = fz(d[11], d[10]);            // R8 polarity bit set
    eb[2] = 1'b0; eb[3] = 1'b0;
    eb[4] = bi[2];                       // R5 pad receive true line
    eb[5] = ~bi[3];                      // R5 pad receive complement line
    eb[6] = 1'b1; eb[7] = 1'b1;
    apply(v);
    chk({tag, " R6 out_o"}, {24'h0, out_o}, {24'h0, eo});
    chk({tag, " R7 xor_o"}, {24'h0, xor_o}, {24'h0, ex});
    chk({tag, " R5 bidir_o"}, {24'h0, bidir_o}, {24'h0, eb});
  endtask

  task automatic check_virgin(input string tag);
    apply(24'h5A_A5C3);
    chk({tag, " R1 out_o"}, {24'h0, out_o}, 32'h0F);
    chk({tag, " R1 xor_o"}, {24'h0, xor_o}, 32'h00);
    chk({tag, " R1 bidir_o"}, {24'h0, bidir_o}, 32'hF0);
  endtask

  task automatic shift_img();
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk); prog_en = 1; prog_bit = img[i];
    end
    @(negedge clk); prog_en = 0; prog_bit = 0;
  endtask

  task automatic pulse_commit();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
  endtask

  task automatic readback(input logic expect_locked, input string tag);
    int bad = 0;
    int first_bad = -1;
    @(negedge clk); recall = 1;
    @(negedge clk); recall = 0;
    for (int i = 0; i < TOTAL; i++) begin
      logic e;
      e = expect_locked ? 1'b0 : img[i];
      if (rdbk_bit !== e) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      prog_en = 1; prog_bit = 0;
      @(negedge clk);
    end
    prog_en = 0;
    chk({tag, " mismatching readback bits"}, bad, 0);
    if (bad != 0) $display("  first mismatch at index %0d", first_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    img = '0;
    con(0, 0);  con(0, 1);
    con(1, 28); con(1, 5);
    con(2, 4);  con(2, 6);
    con(3, 65); con(3, 66);
    con(4, 7);  con(4, 69);
    con(5, 8);
    con(6, 9);  con(6, 70);
    con(72, 10); con(73, 10); con(80, 11); con(81, 11);
    con(76, 50); con(77, 59);
    con(88, 0); con(88, 1); con(89, 67); con(90, 68); con(91, 70); con(92, 64);
    con(99, 12);
    con(100, 2); con(101, 3);
    con(117, 37);
    img[NT*LINES + 1] = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1;
    check_virgin("reset");                          // R1
    shift_img();
    check_virgin("shifted-no-commit R2");           // R2 nothing live yet
    pulse_commit();
    for (int k = 0; k < NVEC; k++) check_prog(VEC[k], "table R2 R3");
    readback(1'b0, "R9");
    check_prog(VEC[11], "after-readback R2");
    @(negedge clk); lock_set = 1;
    @(negedge clk); lock_set = 0;
    readback(1'b1, "R10");
    check_prog(VEC[3], "locked R10");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check_virgin("re-reset R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule